// File: doc/BRIEF.md
# IR-Drop Command Admission Checker

This block sits beside the command scheduler of a memory controller for an eight-die stacked DRAM. Each cycle the scheduler may present one candidate command, with its kind (read, write, activate or precharge) and the die and region it targets. The block replies one cycle later with either a grant or a deny. It grants only when the supply-droop budgets of every scope that covers the target still hold after the candidate's cost is added. The scopes are the region itself, the pair of vertically adjacent regions, the upper or lower four-die half, and the whole stack.

Costs are kept in sixths of a read, so every sum is an integer. Each granted command stays charged to its region for a fixed window of cycles, and its charge is then returned. Regions that sit higher in the stack, or farther from the vertical power vias, get smaller budgets. The scheduler uses a deny as a "try another command" signal. A denied command never changes the budget state.

Top module: `irdrop_admit`

## Requirements
- R1: `grant` and `deny` are registered. They answer the candidate present in the previous cycle. Both are low when `cmd_valid` was low, and exactly one is high when it was high.
- R2: Charges in sixths of a read, selected by `cmd_kind`: 0 = read costs 6, 1 = write costs 6, 2 = activate costs 3, 3 = precharge costs 1.
- R3: Region budget. The region index is 0 for near the vias and 1 for far. Die 0 is the bottom die and die 7 is the top die. Each region may hold at most (REG_BASE − floor(die/2) − region) reads. With the defaults this is 6 reads on die 0 region 0 and 2 reads on die 7 region 1.
- R4: Pair budget. Regions with the same index on dies 2k and 2k+1 together hold at most PAIR_LIMIT reads (default 8).
- R5: Half budget. Dies 0–3 together, and dies 4–7 together, each hold at most HALF_LIMIT reads (default 12).
- R6: Stack budget. The whole stack holds at most 16 reads. The limit drops to 8 reads when any charge is outstanding on dies 4–7 or when the candidate targets dies 4–7.
- R7: Synchronous reset clears all budget state and drives `grant` and `deny` low.
- R8: A command granted in cycle c is counted by candidates in cycles c+1 through c+WINDOW. A candidate in cycle c+WINDOW+1 no longer sees it.
- R9: When a grant and a release hit the same region in the same cycle, both are applied. The region count does not drift.
- R10: A denied command leaves no charge behind.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | A candidate command is present this cycle |
| cmd_kind | input | 2 | 0 read, 1 write, 2 activate, 3 precharge |
| cmd_die | input | 3 | Target die, 0 = bottom |
| cmd_region | input | 1 | Target region in the die, 0 = near the vias |
| grant | output | 1 | Previous candidate admitted and charged |
| deny | output | 1 | Previous candidate refused, nothing charged |

## Verification
All budget state is hidden behind a single grant/deny pair. A corrupted region or group count therefore shows up only as a wrong answer for the next candidate that reaches the affected scope, one cycle after that candidate is presented. Bursts are shaped so that exactly one scope is the binding limit at the point where a grant turns into a deny. A leaked or lost release shows up WINDOW+1 cycles after the original grant, as a deny where a grant was due or the reverse. For this reason the window edge and the case where a grant and a release coincide are probed cycle by cycle.

// File: rtl/irdrop_pkg.sv
package irdrop_pkg;

  typedef enum logic [1:0] {
    CMD_RD  = 2'd0,
    CMD_WR  = 2'd1,
    CMD_ACT = 2'd2,
    CMD_PRE = 2'd3
  } cmd_kind_e;

  // cost unit: one sixth of a read
  localparam int unsigned UNIT   = 6;
  localparam int unsigned COST_W = 3;

  // budget of one region, in sixths, shrinking with height and via distance
  function automatic int unsigned region_cap(int unsigned die, int unsigned reg_i,
                                             int unsigned base);
    return (base - die / 2 - reg_i) * UNIT;
  endfunction

endpackage

// File: rtl/irdrop_cost.sv
module irdrop_cost
  import irdrop_pkg::*;
(
  input  cmd_kind_e         kind,
  output logic [COST_W-1:0] cost
);

  always_comb begin
    case (kind)
      CMD_RD, CMD_WR: cost = COST_W'(6);
      CMD_ACT:        cost = COST_W'(3);
      default:        cost = COST_W'(1);
    endcase
  end

endmodule

// File: rtl/irdrop_release_ring.sv
module irdrop_release_ring #(
  parameter int DEPTH  = 16,
  parameter int IDX_W  = 4,
  parameter int COST_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [IDX_W-1:0]  in_idx,
  input  logic [COST_W-1:0] in_cost,
  output logic              out_valid,
  output logic [IDX_W-1:0]  out_idx,
  output logic [COST_W-1:0] out_cost
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int ENT_W = 1 + IDX_W + COST_W;

  // one slot per cycle of the window; no reset so it maps onto distributed RAM
  logic [ENT_W-1:0] slots [DEPTH];
  logic [PTR_W-1:0] ptr;
  logic             primed;
  logic [ENT_W-1:0] aged;

  assign aged = slots[ptr];

  always_ff @(posedge clk) begin
    slots[ptr] <= {in_valid, in_idx, in_cost};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr    <= '0;
      primed <= 1'b0;
    end else if (ptr == PTR_W'(DEPTH - 1)) begin
      ptr    <= '0;
      primed <= 1'b1;
    end else begin
      ptr    <= ptr + 1'b1;
    end
  end

  // slots from before the first full lap hold stale data
  assign out_valid = primed & aged[ENT_W-1];
  assign out_idx   = aged[COST_W +: IDX_W];
  assign out_cost  = aged[COST_W-1:0];

endmodule

// File: rtl/irdrop_budget.sv
module irdrop_budget
  import irdrop_pkg::*;
#(
  parameter int NUM_DIES        = 8,
  parameter int RPD             = 2,
  parameter int REG_BASE        = 6,
  parameter int PAIR_LIMIT      = 8,
  parameter int HALF_LIMIT      = 12,
  parameter int STACK_LIMIT_ALL = 16,
  parameter int STACK_LIMIT_TOP = 8,
  localparam int NR    = NUM_DIES * RPD,
  localparam int NP    = NR / 2,
  localparam int IDX_W = $clog2(NR),
  localparam int CW    = $clog2(REG_BASE * UNIT + 1),
  localparam int SW    = CW + IDX_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cand_valid,
  input  logic [IDX_W-1:0]  cand_idx,
  input  logic [COST_W-1:0] cand_cost,
  input  logic              cand_top,
  input  logic              rel_valid,
  input  logic [IDX_W-1:0]  rel_idx,
  input  logic [COST_W-1:0] rel_cost,
  output logic              admit,
  output logic [NR*CW-1:0]  fill_flat,
  output logic [SW-1:0]     total_fill
);

  logic [CW-1:0] cnt      [NR];
  logic [CW-1:0] cnt_nxt  [NR];
  logic [SW-1:0] cap_tab  [NR];
  logic [SW-1:0] pair_sum [NR];
  logic [SW-1:0] half_sum [2];
  logic [SW-1:0] total;

  // group sums are rebuilt from the region counts each cycle
  always_comb begin
    total       = '0;
    half_sum[0] = '0;
    half_sum[1] = '0;
    for (int i = 0; i < NR; i++) begin
      cap_tab[i] = SW'(region_cap(int'(i / RPD), int'(i % RPD), REG_BASE));
      total      = total + SW'(cnt[i]);
      if (i / RPD >= NUM_DIES / 2) half_sum[1] = half_sum[1] + SW'(cnt[i]);
      else                         half_sum[0] = half_sum[0] + SW'(cnt[i]);
    end
    for (int p = 0; p < NR; p++) begin
      if (p < NP) begin
        pair_sum[p] = SW'(cnt[(p / RPD) * 2 * RPD + p % RPD])
                    + SW'(cnt[(p / RPD) * 2 * RPD + p % RPD + RPD]);
      end else begin
        pair_sum[p] = '0;
      end
    end
  end

  logic [SW-1:0]    c_w;
  logic [IDX_W-1:0] cand_pair;
  logic             reg_ok, pair_ok, half_ok, stack_ok, top_on;
  logic [SW-1:0]    stack_cap;

  assign c_w = SW'(cand_cost);

  always_comb begin
    int cd;
    int cr;
    cd        = int'(cand_idx) / RPD;
    cr        = int'(cand_idx) % RPD;
    cand_pair = IDX_W'((cd / 2) * RPD + cr);
    reg_ok    = (SW'(cnt[cand_idx]) + c_w) <= cap_tab[cand_idx];
    pair_ok   = (pair_sum[cand_pair] + c_w) <= SW'(PAIR_LIMIT * UNIT);
    half_ok   = (half_sum[cand_top] + c_w) <= SW'(HALF_LIMIT * UNIT);
    top_on    = cand_top | (half_sum[1] != '0);
    stack_cap = top_on ? SW'(STACK_LIMIT_TOP * UNIT) : SW'(STACK_LIMIT_ALL * UNIT);
    stack_ok  = (total + c_w) <= stack_cap;
    admit     = cand_valid & reg_ok & pair_ok & half_ok & stack_ok;
  end

  // charge and release are summed so a coincident pair nets out
  always_comb begin
    for (int i = 0; i < NR; i++) begin
      cnt_nxt[i] = cnt[i];
      if (admit && cand_idx == IDX_W'(i))    cnt_nxt[i] = cnt_nxt[i] + CW'(cand_cost);
      if (rel_valid && rel_idx == IDX_W'(i)) cnt_nxt[i] = cnt_nxt[i] - CW'(rel_cost);
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < NR; i++) begin
      if (rst) cnt[i] <= '0;
      else     cnt[i] <= cnt_nxt[i];
    end
  end

  genvar g;
  generate
    for (g = 0; g < NR; g++) begin : g_fill
      assign fill_flat[g*CW +: CW] = cnt[g];
    end
  endgenerate

  assign total_fill = total;

endmodule

// File: rtl/irdrop_admit.sv
module irdrop_admit
  import irdrop_pkg::*;
#(
  parameter int NUM_DIES        = 8,
  parameter int REGIONS_PER_DIE = 2,
  parameter int WINDOW          = 16,
  parameter int REG_BASE        = 6,
  parameter int PAIR_LIMIT      = 8,
  parameter int HALF_LIMIT      = 12,
  parameter int STACK_LIMIT_ALL = 16,
  parameter int STACK_LIMIT_TOP = 8,
  localparam int DIE_W = $clog2(NUM_DIES),
  localparam int REG_W = $clog2(REGIONS_PER_DIE),
  localparam int NR    = NUM_DIES * REGIONS_PER_DIE,
  localparam int IDX_W = $clog2(NR),
  localparam int CW    = $clog2(REG_BASE * UNIT + 1),
  localparam int SW    = CW + IDX_W + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_valid,
  input  logic [1:0]       cmd_kind,
  input  logic [DIE_W-1:0] cmd_die,
  input  logic [REG_W-1:0] cmd_region,
  output logic             grant,
  output logic             deny
);

  logic [COST_W-1:0] cost;
  logic [IDX_W-1:0]  cand_idx;
  logic              cand_top;
  logic              cand_valid;
  logic              admit;
  logic              rel_valid;
  logic [IDX_W-1:0]  rel_idx;
  logic [COST_W-1:0] rel_cost;
  logic [NR*CW-1:0]  fill_flat;
  logic [SW-1:0]     total_fill;

  assign cand_idx   = IDX_W'(int'(cmd_die) * REGIONS_PER_DIE + int'(cmd_region));
  assign cand_top   = int'(cmd_die) >= NUM_DIES / 2;
  assign cand_valid = cmd_valid & ~rst;

  irdrop_cost u_cost (
    .kind (cmd_kind_e'(cmd_kind)),
    .cost (cost)
  );

  irdrop_budget #(
    .NUM_DIES        (NUM_DIES),
    .RPD             (REGIONS_PER_DIE),
    .REG_BASE        (REG_BASE),
    .PAIR_LIMIT      (PAIR_LIMIT),
    .HALF_LIMIT      (HALF_LIMIT),
    .STACK_LIMIT_ALL (STACK_LIMIT_ALL),
    .STACK_LIMIT_TOP (STACK_LIMIT_TOP)
  ) u_budget (
    .clk        (clk),
    .rst        (rst),
    .cand_valid (cand_valid),
    .cand_idx   (cand_idx),
    .cand_cost  (cost),
    .cand_top   (cand_top),
    .rel_valid  (rel_valid),
    .rel_idx    (rel_idx),
    .rel_cost   (rel_cost),
    .admit      (admit),
    .fill_flat  (fill_flat),
    .total_fill (total_fill)
  );

  irdrop_release_ring #(
    .DEPTH  (WINDOW),
    .IDX_W  (IDX_W),
    .COST_W (COST_W)
  ) u_ring (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (admit),
    .in_idx    (cand_idx),
    .in_cost   (cost),
    .out_valid (rel_valid),
    .out_idx   (rel_idx),
    .out_cost  (rel_cost)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      grant <= 1'b0;
      deny  <= 1'b0;
    end else begin
      grant <= admit;
      deny  <= cmd_valid & ~admit;
    end
  end

endmodule

// File: rtl/irdrop_admit_chk.sv
module irdrop_admit_chk
  import irdrop_pkg::*;
#(
  parameter int NUM_DIES        = 8,
  parameter int RPD             = 2,
  parameter int REG_BASE        = 6,
  parameter int STACK_LIMIT_ALL = 16,
  parameter int STACK_LIMIT_TOP = 8,
  parameter int NR              = 16,
  parameter int CW              = 6,
  parameter int SW              = 11
) (
  input logic             clk,
  input logic             rst,
  input logic             cmd_valid,
  input logic             grant,
  input logic             deny,
  input logic [NR*CW-1:0] fill,
  input logic [SW-1:0]    total
);

  logic [SW-1:0] top_fill;

  always_comb begin
    top_fill = '0;
    for (int i = 0; i < NR; i++) begin
      if (i / RPD >= NUM_DIES / 2) top_fill = top_fill + SW'(fill[i*CW +: CW]);
    end
  end

  // R1
  grant_deny_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(grant && deny));

  // R1
  answer_follows_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ((grant || deny) == $past(cmd_valid)));

  // R6
  stack_all_cap_chk: assert property (@(posedge clk) disable iff (rst)
    total <= SW'(STACK_LIMIT_ALL * UNIT));

  // R6
  stack_top_cap_chk: assert property (@(posedge clk) disable iff (rst)
    (top_fill != '0) |-> (total <= SW'(STACK_LIMIT_TOP * UNIT)));

  // R7
  reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (total == '0 && !grant && !deny));

  genvar g;
  generate
    for (g = 0; g < NR; g++) begin : g_cap
      // R3
      region_cap_chk: assert property (@(posedge clk) disable iff (rst)
        fill[g*CW +: CW] <= CW'(region_cap(g / RPD, g % RPD, REG_BASE)));
    end
  endgenerate

endmodule

bind irdrop_admit irdrop_admit_chk #(
  .NUM_DIES        (NUM_DIES),
  .RPD             (REGIONS_PER_DIE),
  .REG_BASE        (REG_BASE),
  .STACK_LIMIT_ALL (STACK_LIMIT_ALL),
  .STACK_LIMIT_TOP (STACK_LIMIT_TOP),
  .NR              (NR),
  .CW              (CW),
  .SW              (SW)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .cmd_valid (cmd_valid),
  .grant     (grant),
  .deny      (deny),
  .fill      (fill_flat),
  .total     (total_fill)
);

// File: tb/sim_irdrop_admit.sv
module sim_irdrop_admit;

  localparam int W  = 16;
  localparam int RD = 0;
  localparam int WR = 1;
  localparam int AC = 2;
  localparam int PR = 3;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cmd_valid = 1'b0;
  logic [1:0] cmd_kind = 2'd0;
  logic [2:0] cmd_die = 3'd0;
  logic [0:0] cmd_region = 1'b0;
  logic       grant, deny;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  irdrop_admit #(.WINDOW(W)) u0 (
    .clk        (clk),
    .rst        (rst),
    .cmd_valid  (cmd_valid),
    .cmd_kind   (cmd_kind),
    .cmd_die    (cmd_die),
    .cmd_region (cmd_region),
    .grant      (grant),
    .deny       (deny)
  );

  // fields: [12:9] requirement, [8] drain after, [7] valid, [6:5] kind, [4:2] die, [1] region, [0] expect grant
  function automatic logic [12:0] v(int req, bit last, bit vld, int k, int d, int r, bit e);
    return {4'(req), last, vld, 2'(k), 3'(d), 1'(r), e};
  endfunction

  localparam int NV = 62;
  localparam logic [12:0] VEC [NV] = '{
    // R1: idle cycle answers with neither
    v(1,0,0,RD,0,0,0),
    // R2: mixed kinds fill die0 region0 (cap 36 sixths) exactly, one precharge over
    v(2,0,1,RD,0,0,1), v(2,0,1,WR,0,0,1), v(2,0,1,RD,0,0,1), v(2,0,1,WR,0,0,1),
    v(2,0,1,RD,0,0,1), v(2,0,1,AC,0,0,1), v(2,0,1,PR,0,0,1), v(2,0,1,PR,0,0,1),
    v(2,0,1,PR,0,0,1), v(2,1,1,PR,0,0,0),
    // R4: dies 0/1 region0 pair reaches 8 reads, other pair still free
    v(4,0,1,RD,0,0,1), v(4,0,1,RD,0,0,1), v(4,0,1,RD,0,0,1), v(4,0,1,RD,0,0,1),
    v(4,0,1,RD,0,0,1), v(4,0,1,RD,1,0,1), v(4,0,1,RD,1,0,1), v(4,0,1,RD,1,0,1),
    v(4,0,1,RD,1,0,0), v(4,1,1,RD,1,1,1),
    // R5: bottom half reaches 12 reads spread over pairs
    v(5,0,1,RD,2,0,1), v(5,0,1,RD,2,0,1), v(5,0,1,RD,2,0,1), v(5,0,1,RD,2,0,1),
    v(5,0,1,RD,2,0,1), v(5,0,1,RD,3,1,1), v(5,0,1,RD,3,1,1), v(5,0,1,RD,3,1,1),
    v(5,0,1,RD,3,1,1), v(5,0,1,RD,0,1,1), v(5,0,1,RD,0,1,1), v(5,0,1,RD,0,1,1),
    v(5,1,1,RD,1,0,0),
    // R6: a top charge caps the stack at 8 reads
    v(6,0,1,RD,7,0,1), v(6,0,1,RD,0,0,1), v(6,0,1,RD,0,0,1), v(6,0,1,RD,0,0,1),
    v(6,0,1,RD,0,0,1), v(6,0,1,RD,0,0,1), v(6,0,1,RD,1,1,1), v(6,0,1,RD,1,1,1),
    v(6,1,1,RD,2,0,0),
    // R6: a top candidate meets the 8 read cap, a bottom one the 16 read cap
    v(6,0,1,RD,0,0,1), v(6,0,1,RD,0,0,1), v(6,0,1,RD,0,0,1), v(6,0,1,RD,0,0,1),
    v(6,0,1,RD,0,0,1), v(6,0,1,RD,1,1,1), v(6,0,1,RD,1,1,1), v(6,0,1,RD,1,1,1),
    v(6,0,1,RD,6,0,0), v(6,1,1,RD,2,0,1),
    // R10: die7 region1 (cap 12): a denied read must leave room for five precharges
    v(10,0,1,RD,7,1,1), v(10,0,1,PR,7,1,1), v(10,0,1,RD,7,1,0), v(10,0,1,PR,7,1,1),
    v(10,0,1,PR,7,1,1), v(10,0,1,PR,7,1,1), v(10,0,1,PR,7,1,1), v(10,0,1,PR,7,1,1),
    v(10,1,1,PR,7,1,0)
  };

  task automatic check_out(int req, bit eg, bit ed, string what);
    checks++;
    if (grant !== eg || deny !== ed) begin
      errors++;
      $display("FAIL R%0d %s: grant,deny=%b%b expected %b%b", req, what, grant, deny, eg, ed);
    end
  endtask

  task automatic drive(bit vld, int k, int d, int r);
    cmd_valid  = vld;
    cmd_kind   = 2'(k);
    cmd_die    = 3'(d);
    cmd_region = 1'(r);
  endtask

  task automatic issue(int req, bit vld, int k, int d, int r, bit eg, string what);
    drive(vld, k, d, r);
    @(negedge clk);
    check_out(req, eg & vld, vld & ~eg, what);
  endtask

  task automatic idle_n(int n);
    drive(1'b0, RD, 0, 0);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R1 watchdog: run still active, expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R7: outputs low while reset holds
    check_out(7, 1'b0, 1'b0, "reset state");
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      logic [12:0] e;
      e = VEC[i];
      issue(int'(e[12:9]), e[7], int'(e[6:5]), int'(e[4:2]), int'(e[1]), e[0], "vector");
      if (e[8]) idle_n(W + 2);
    end

    // R8: charge visible through cycle c+W, gone at c+W+1
    issue(8, 1, RD, 7, 1, 1, "window first");
    issue(8, 1, RD, 7, 1, 1, "window second");
    idle_n(W - 2);
    issue(8, 1, RD, 7, 1, 0, "window last held cycle");
    issue(8, 1, RD, 7, 1, 1, "window released");
    // R9: grant and release land together, count must stay at one read
    issue(9, 1, RD, 7, 1, 1, "net after coincident");
    issue(9, 1, RD, 7, 1, 0, "full after net");
    idle_n(W + 2);

    // R7: reset mid-run clears a full region
    issue(7, 1, RD, 7, 1, 1, "pre-reset fill");
    issue(7, 1, RD, 7, 1, 1, "pre-reset fill");
    drive(1'b0, RD, 0, 0);
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check_out(7, 1'b0, 1'b0, "outputs in reset");
    rst = 1'b0;
    issue(7, 1, RD, 7, 1, 1, "cleared region");
    issue(7, 1, RD, 7, 1, 1, "cleared region");
    issue(7, 1, RD, 7, 1, 0, "refill to cap");
    idle_n(2);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule